// File: doc/BRIEF.md
# Register Rename History Log

This block keeps an ordered record of every destination-register rename made by a small single-thread out-of-order core. It owns the architectural-to-physical map table and the physical-register free list. Each record pairs the physical register newly given to an architectural register with the physical register it replaced. Keeping both values in one record lets the same log serve two purposes. When instructions retire, the displaced register is released late and safely. When the pipeline is flushed, the old mapping is put back.

Each cycle the front end offers up to `RN_WIDTH` destinations, each tagged with its sequence number. The block grants an in-order prefix of them, hands out the lowest-numbered free physical registers, and appends one record per granted lane. A commit port retires the oldest records up to a given sequence number. A squash port starts a walk that undoes records, youngest first, one per cycle. While the walk runs, renaming is held off. Source operands are looked up combinationally from the map.

Top module: `rnlog_top`

## Requirements
- R1: After reset, architectural register i maps to physical register i, physical registers 8 to 15 are free (`free_cnt` = 8), and `walk_busy` is 0.
- R2: A granted lane receives the lowest-numbered free physical register. Lane 0 takes the lowest and lane 1 the next. `rn_old` reports the register the destination mapped to, including a mapping made by lane 0 in the same cycle. `src_phys` shows the new mapping from the next cycle.
- R3: Grants form a prefix of the lanes. A lane is granted only if it is valid, every lower lane is granted, a free register is left for it, and the log has room. Lane 1 is therefore never granted while lane 0 is idle.
- R4: With `cm_valid`, records are retired from the oldest end while their sequence number is not younger than `cm_seq`. At most `CM_WIDTH` records retire per cycle. Each retired record's displaced register becomes free at the next clock edge.
- R5: A `sq_valid` pulse with sequence S sets `walk_busy` from the next cycle. Each busy cycle handles the youngest record. If that record is younger than S, its architectural register is restored to the displaced register and its new register is freed. Otherwise the walk ends and `walk_busy` drops after that cycle. A walk that undoes n records therefore keeps `walk_busy` high for n+1 cycles.
- R6: No lane is granted while `walk_busy` is 1, and none is granted in a cycle where `sq_valid` is 1.
- R7: Sequence numbers are 8-bit wrapping values. Sequence a is younger than b when (a-b) mod 256 is between 1 and 127, so 0 is younger than 255.
- R8: A commit and a squash-walk step in the same cycle both take effect. The commit consumes the oldest records and the walk consumes the youngest.
- R9: Free registers plus log records always total 8, which is the number of physical registers beyond the architectural ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rn_valid | input | RN_WIDTH | Per-lane rename request |
| rn_seq | input | RN_WIDTH*8 | Per-lane sequence number, lane 0 in the low bits |
| rn_dst | input | RN_WIDTH*3 | Per-lane destination architectural register |
| rn_grant | output | RN_WIDTH | Lanes renamed this cycle (combinational) |
| rn_new | output | RN_WIDTH*4 | Newly allocated physical register per lane |
| rn_old | output | RN_WIDTH*4 | Displaced physical register per lane |
| src_arch | input | 3 | Source architectural register to look up |
| src_phys | output | 4 | Current physical mapping of `src_arch` |
| cm_valid | input | 1 | Commit request |
| cm_seq | input | 8 | Youngest sequence number that may retire |
| sq_valid | input | 1 | Squash request |
| sq_seq | input | 8 | Squash point; younger records are undone |
| walk_busy | output | 1 | Squash walk in progress |
| free_cnt | output | 5 | Number of free physical registers |

## Verification
A commit and a squash-walk step can occur in the same cycle. The commit removes records from the old end of the ring while the walk removes one from the young end, and both return registers to the free list. The bench provokes this by raising `cm_valid` in the first busy cycle after a squash, while a rename request is also presented. It then checks that the grant stays low, that `free_cnt` rises by exactly two, and that only the youngest record's mapping has been restored. The later walk length and final map contents confirm that neither side consumed the other's record.

// File: rtl/rnlog_pkg.sv
package rnlog_pkg;
    localparam int ARCH_W   = 3;
    localparam int PHYS_W   = 4;
    localparam int SEQ_W    = 8;
    localparam int NUM_ARCH = 1 << ARCH_W;
    localparam int NUM_PHYS = 1 << PHYS_W;
    localparam int FCNT_W   = $clog2(NUM_PHYS + 1);

    typedef logic [SEQ_W-1:0]  seq_t;
    typedef logic [ARCH_W-1:0] arch_t;
    typedef logic [PHYS_W-1:0] phys_t;

    // one rename record: who renamed, which register, what it got, what it lost
    typedef struct packed {
        seq_t  seq;
        arch_t arch;
        phys_t newp;
        phys_t oldp;
    } hent_t;

    // wrapping age compare: a strictly younger than b
    function automatic logic seq_younger(seq_t a, seq_t b);
        seq_t diff;
        diff = a - b;
        return (diff != '0) && !diff[SEQ_W-1];
    endfunction
endpackage

// File: rtl/rnlog_pick.sv
module rnlog_pick
    import rnlog_pkg::*;
#(
    parameter int LANES = 2
) (
    input  logic [NUM_PHYS-1:0] free_vec,
    output phys_t               pick_idx [LANES],
    output logic [LANES-1:0]    pick_ok
);
    // successive lowest-set-bit search, one removed per lane
    always_comb begin
        logic [NUM_PHYS-1:0] rem;
        logic                found;
        phys_t               idx;
        rem = free_vec;
        for (int k = 0; k < LANES; k++) begin
            found = 1'b0;
            idx   = '0;
            for (int i = 0; i < NUM_PHYS; i++) begin
                if (!found && rem[i]) begin
                    found = 1'b1;
                    idx   = phys_t'(i);
                end
            end
            if (found) rem[idx] = 1'b0;
            pick_ok[k]  = found;
            pick_idx[k] = idx;
        end
    end
endmodule

// File: rtl/rnlog_store.sv
module rnlog_store
    import rnlog_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int LANES  = 2,
    parameter int RETIRE = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [LANES-1:0]         wr_en,
    input  logic [$clog2(DEPTH)-1:0] wr_ptr,
    input  hent_t                    wr_ent [LANES],
    input  logic [$clog2(DEPTH)-1:0] head_ptr,
    output hent_t                    head_ent [RETIRE],
    input  logic [$clog2(DEPTH)-1:0] tail_ptr,
    output hent_t                    last_ent
);
    localparam int PTR_W = $clog2(DEPTH);

    hent_t [DEPTH-1:0] mem_q, mem_d;
    logic  [PTR_W-1:0] last_idx;

    always_comb begin
        mem_d = mem_q;
        for (int k = 0; k < LANES; k++) begin
            if (wr_en[k]) mem_d[wr_ptr + PTR_W'(k)] = wr_ent[k];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) mem_q <= '0;
        else        mem_q <= mem_d;
    end

    genvar j;
    generate
        for (j = 0; j < RETIRE; j++) begin : g_head_rd
            assign head_ent[j] = mem_q[head_ptr + PTR_W'(j)];
        end
    endgenerate

    assign last_idx = tail_ptr - 1'b1;
    assign last_ent = mem_q[last_idx];
endmodule

// File: rtl/rnlog_top.sv
module rnlog_top
    import rnlog_pkg::*;
#(
    parameter int DEPTH    = 16,
    parameter int RN_WIDTH = 2,
    parameter int CM_WIDTH = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [RN_WIDTH-1:0]        rn_valid,
    input  logic [RN_WIDTH*SEQ_W-1:0]  rn_seq,
    input  logic [RN_WIDTH*ARCH_W-1:0] rn_dst,
    output logic [RN_WIDTH-1:0]        rn_grant,
    output logic [RN_WIDTH*PHYS_W-1:0] rn_new,
    output logic [RN_WIDTH*PHYS_W-1:0] rn_old,
    input  logic [ARCH_W-1:0]          src_arch,
    output logic [PHYS_W-1:0]          src_phys,
    input  logic                       cm_valid,
    input  logic [SEQ_W-1:0]           cm_seq,
    input  logic                       sq_valid,
    input  logic [SEQ_W-1:0]           sq_seq,
    output logic                       walk_busy,
    output logic [FCNT_W-1:0]          free_cnt
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam logic [NUM_PHYS-1:0] FREE_RST = {NUM_PHYS{1'b1}} << NUM_ARCH;

    typedef struct packed {
        logic [NUM_ARCH-1:0][PHYS_W-1:0] map;
        logic [NUM_PHYS-1:0]             free;
        logic [PTR_W-1:0]                head;
        logic [PTR_W-1:0]                tail;
        logic                            full;
        logic                            walk;
        seq_t                            stop_seq;
    } st_t;

    st_t s_q, s_d;

    phys_t             pick_idx [RN_WIDTH];
    logic [RN_WIDTH-1:0] pick_ok;
    logic [RN_WIDTH-1:0] wr_en;
    hent_t             wr_ent [RN_WIDTH];
    hent_t             head_ent [CM_WIDTH];
    hent_t             last_ent;

    int    used_q, used_d, n_ret, n_grant;
    logic  ret_go, go, undo;
    arch_t dst;
    phys_t old_p;

    assign used_q = s_q.full ? DEPTH : int'(s_q.tail - s_q.head);

    rnlog_pick #(.LANES(RN_WIDTH)) u_pick (
        .free_vec (s_q.free),
        .pick_idx (pick_idx),
        .pick_ok  (pick_ok)
    );

    rnlog_store #(.DEPTH(DEPTH), .LANES(RN_WIDTH), .RETIRE(CM_WIDTH)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_ptr   (s_q.tail),
        .wr_ent   (wr_ent),
        .head_ptr (s_q.head),
        .head_ent (head_ent),
        .tail_ptr (s_q.tail),
        .last_ent (last_ent)
    );

    always_comb begin
        s_d      = s_q;
        rn_grant = '0;
        rn_new   = '0;
        rn_old   = '0;
        wr_en    = '0;
        for (int k = 0; k < RN_WIDTH; k++) wr_ent[k] = '0;
        n_ret   = 0;
        n_grant = 0;
        undo    = 1'b0;
        dst     = '0;
        old_p   = '0;

        // retire from the old end, in order, stop at first younger record
        ret_go = cm_valid;
        for (int j = 0; j < CM_WIDTH; j++) begin
            ret_go = ret_go && (j < used_q) && !seq_younger(head_ent[j].seq, cm_seq);
            if (ret_go) begin
                s_d.free[head_ent[j].oldp] = 1'b1;
                n_ret = n_ret + 1;
            end
        end

        // squash walk: one youngest record per cycle
        if (s_q.walk) begin
            if ((used_q > n_ret) && seq_younger(last_ent.seq, s_q.stop_seq)) begin
                undo = 1'b1;
                s_d.map[last_ent.arch] = last_ent.oldp;
                s_d.free[last_ent.newp] = 1'b1;
            end else begin
                s_d.walk = 1'b0;
            end
        end
        if (sq_valid) begin
            s_d.walk     = 1'b1;
            s_d.stop_seq = sq_seq;
        end

        // rename: in-order prefix of lanes
        go = !s_q.walk && !sq_valid;
        for (int k = 0; k < RN_WIDTH; k++) begin
            go  = go && rn_valid[k] && pick_ok[k] && ((used_q + k) < DEPTH);
            dst = rn_dst[k*ARCH_W +: ARCH_W];
            if (go) begin
                old_p = s_d.map[dst];
                rn_grant[k] = 1'b1;
                rn_new[k*PHYS_W +: PHYS_W] = pick_idx[k];
                rn_old[k*PHYS_W +: PHYS_W] = old_p;
                s_d.map[dst] = pick_idx[k];
                s_d.free[pick_idx[k]] = 1'b0;
                wr_en[k] = 1'b1;
                wr_ent[k].seq  = rn_seq[k*SEQ_W +: SEQ_W];
                wr_ent[k].arch = dst;
                wr_ent[k].newp = pick_idx[k];
                wr_ent[k].oldp = old_p;
                n_grant = n_grant + 1;
            end
        end

        s_d.head = s_q.head + PTR_W'(n_ret);
        s_d.tail = s_q.tail + PTR_W'(n_grant) - PTR_W'(undo);
        used_d   = used_q + n_grant - n_ret - (undo ? 1 : 0);
        s_d.full = (used_d == DEPTH);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_ARCH; i++) s_q.map[i] <= PHYS_W'(i);
            s_q.free     <= FREE_RST;
            s_q.head     <= '0;
            s_q.tail     <= '0;
            s_q.full     <= 1'b0;
            s_q.walk     <= 1'b0;
            s_q.stop_seq <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign src_phys  = s_q.map[src_arch];
    assign walk_busy = s_q.walk;
    assign free_cnt  = FCNT_W'($countones(s_q.free));

    AST_GRANT_PREFIX: assert property (@(posedge clk) disable iff (!rst_n)
        ((rn_grant + RN_WIDTH'(1)) & rn_grant) == '0)
        else $error("grant not a lane prefix"); // R3
    AST_HOLD_DURING_WALK: assert property (@(posedge clk) disable iff (!rst_n)
        (walk_busy || sq_valid) |-> (rn_grant == '0))
        else $error("rename granted during squash"); // R6
    AST_WALK_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
        sq_valid |=> walk_busy)
        else $error("walk did not start"); // R5
    AST_ALLOC_FROM_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        rn_grant[0] |-> s_q.free[rn_new[PHYS_W-1:0]])
        else $error("allocated a busy register"); // R2
    AST_REG_CONSERVE: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(free_cnt) + used_q) == (NUM_PHYS - NUM_ARCH))
        else $error("register count leak"); // R9
endmodule

// File: tb/rnlog_top_tb_top.sv
module rnlog_top_tb_top;
    import rnlog_pkg::*;
    localparam int RW = 2;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic                  rst_n    = 1'b0;
    logic [RW-1:0]         rn_valid = '0;
    logic [RW*SEQ_W-1:0]   rn_seq   = '0;
    logic [RW*ARCH_W-1:0]  rn_dst   = '0;
    logic [RW-1:0]         rn_grant;
    logic [RW*PHYS_W-1:0]  rn_new, rn_old;
    logic [ARCH_W-1:0]     src_arch = '0;
    logic [PHYS_W-1:0]     src_phys;
    logic                  cm_valid = 1'b0;
    logic [SEQ_W-1:0]      cm_seq   = '0;
    logic                  sq_valid = 1'b0;
    logic [SEQ_W-1:0]      sq_seq   = '0;
    logic                  walk_busy;
    logic [FCNT_W-1:0]     free_cnt;

    int n_chk  = 0;
    int n_fail = 0;

    rnlog_top #(.DEPTH(16), .RN_WIDTH(RW), .CM_WIDTH(2)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .rn_valid(rn_valid), .rn_seq(rn_seq), .rn_dst(rn_dst),
        .rn_grant(rn_grant), .rn_new(rn_new), .rn_old(rn_old),
        .src_arch(src_arch), .src_phys(src_phys),
        .cm_valid(cm_valid), .cm_seq(cm_seq),
        .sq_valid(sq_valid), .sq_seq(sq_seq),
        .walk_busy(walk_busy), .free_cnt(free_cnt)
    );

    task automatic chk(input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", what, act, exp);
        end
    endtask

    task automatic look(input int a, input int exp, input string what);
        src_arch = ARCH_W'(a);
        #1;
        chk(what, int'(src_phys), exp);
    endtask

    // entered and left at a falling edge, inputs idle on exit
    task automatic rn(input int v, input int s0, input int a0, input int s1, input int a1,
                      input int eg, input int en0, input int eo0, input int en1, input int eo1,
                      input string what);
        rn_valid = RW'(v);
        rn_seq   = {SEQ_W'(s1), SEQ_W'(s0)};
        rn_dst   = {ARCH_W'(a1), ARCH_W'(a0)};
        #2;
        chk({what, " grant"}, int'(rn_grant), eg);
        if (eg[0]) begin
            chk({what, " new0"}, int'(rn_new[PHYS_W-1:0]), en0);
            chk({what, " old0"}, int'(rn_old[PHYS_W-1:0]), eo0);
        end
        if (eg[1]) begin
            chk({what, " new1"}, int'(rn_new[2*PHYS_W-1:PHYS_W]), en1);
            chk({what, " old1"}, int'(rn_old[2*PHYS_W-1:PHYS_W]), eo1);
        end
        @(negedge clk);
        rn_valid = '0;
    endtask

    task automatic commit(input int s);
        cm_valid = 1'b1;
        cm_seq   = SEQ_W'(s);
        @(negedge clk);
        cm_valid = 1'b0;
    endtask

    task automatic squash_start(input int s, input string what);
        sq_valid = 1'b1;
        sq_seq   = SEQ_W'(s);
        rn_valid = 2'b01;
        rn_seq   = {SEQ_W'(0), SEQ_W'(s + 1)};
        rn_dst   = '0;
        #2;
        chk({what, " no grant on squash cycle"}, int'(rn_grant), 0);
        @(negedge clk);
        sq_valid = 1'b0;
        rn_valid = '0;
        chk({what, " busy after squash"}, int'(walk_busy), 1);
    endtask

    task automatic walk_len(input int exp, input string what);
        int n;
        n = 0;
        while (walk_busy && n < 50) begin
            n++;
            @(negedge clk);
        end
        chk(what, n, exp);
    endtask

    task automatic t_reset;
        chk("R1 free count", int'(free_cnt), 8);
        chk("R1 busy", int'(walk_busy), 0);
        for (int i = 0; i < NUM_ARCH; i++) look(i, i, "R1 identity map");
    endtask

    task automatic t_rename_basic;
        rn(3, 10, 1, 11, 1, 3, 8, 1, 9, 8, "R2 same-dest pair");
        look(1, 9, "R2 map after pair");
        chk("R2 free after pair", int'(free_cnt), 6);
        rn(1, 12, 2, 0, 0, 1, 10, 2, 0, 0, "R2 single lane");
        rn(2, 0, 0, 13, 5, 0, 0, 0, 0, 0, "R3 lane1 alone");
        look(5, 5, "R3 map untouched");
        chk("R9 free with three records", int'(free_cnt), 5);
    endtask

    task automatic t_commit;
        commit(11);
        chk("R4 two retired", int'(free_cnt), 7);
        commit(11);
        chk("R4 younger record kept", int'(free_cnt), 7);
    endtask

    task automatic t_exhaust;
        rn(3, 13, 3, 14, 4, 3, 1, 3, 8, 4, "R2 lowest-first");
        rn(3, 15, 5, 16, 6, 3, 11, 5, 12, 6, "R2 pair 15/16");
        rn(3, 17, 7, 18, 0, 3, 13, 7, 14, 0, "R2 pair 17/18");
        rn(3, 19, 3, 20, 4, 1, 15, 1, 0, 0, "R3 last register");
        chk("R3 free empty", int'(free_cnt), 0);
        rn(1, 20, 4, 0, 0, 0, 0, 0, 0, 0, "R3 no free register");
        commit(19);
        chk("R4 commit width limit", int'(free_cnt), 2);
    endtask

    task automatic t_squash_with_commit;
        squash_start(16, "R6");
        // first walk cycle: commit and a rename attempt at the same time
        cm_valid = 1'b1;
        cm_seq   = SEQ_W'(14);
        rn_valid = 2'b01;
        rn_seq   = {SEQ_W'(0), SEQ_W'(40)};
        rn_dst   = '0;
        #2;
        chk("R6 no grant while busy", int'(rn_grant), 0);
        @(negedge clk);
        cm_valid = 1'b0;
        rn_valid = '0;
        chk("R8 commit plus undo frees two", int'(free_cnt), 4);
        look(3, 1, "R5 youngest undone first");
        look(0, 14, "R5 older not yet undone");
        walk_len(3, "R5 walk length");
        chk("R5 free after walk", int'(free_cnt), 6);
        look(0, 0, "R5 restore a0");
        look(7, 7, "R5 restore a7");
        look(5, 11, "R5 kept a5");
        look(6, 12, "R8 kept a6");
    endtask

    task automatic t_wrap;
        commit(16);
        chk("R4 log drained", int'(free_cnt), 8);
        rn(3, 254, 1, 255, 2, 3, 2, 9, 3, 10, "R7 pre-wrap pair");
        rn(3, 0, 3, 1, 4, 3, 4, 1, 5, 8, "R7 post-wrap pair");
        squash_start(255, "R7");
        walk_len(3, "R7 wrapped walk length");
        chk("R7 free after wrapped squash", int'(free_cnt), 6);
        look(3, 1, "R7 restore a3");
        look(4, 8, "R7 restore a4");
        look(1, 2, "R7 pre-wrap kept");
        commit(255);
        chk("R7 wrapped commit", int'(free_cnt), 8);
        commit(255);
        chk("R4 commit on empty log", int'(free_cnt), 8);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_rename_basic();
        t_commit();
        t_exhaust();
        t_squash_with_commit();
        t_wrap();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule